// File: doc/BRIEF.md
# Miss and Write Queue Stall Controller

This block keeps track of how full two request queues of a cache controller are. One queue holds outstanding misses and the other holds writes and writebacks on their way to the next level. A request arriving from the processor side names its target queue, an address and a command. The controller aligns the address to a cache block and picks a free slot for it. It also hands out an order tag from one counter that both queues share. Later inputs mark a slot as sent downstream and release it when its transaction completes.

Each reason for refusing new work has its own bit in a stall mask. Bit 0 means the miss queue is full. Bit 1 means the write buffer is full. Bit 2 means no target slots are left, and that bit is driven from outside the block. The processor-side ready signal falls when the mask leaves zero and rises only when the mask returns to zero. If a request was refused during the stall, a one-cycle retry pulse goes out when ready rises. The controller counts stall episodes per cause and the stalled cycles per cause. A loadable miss countdown raises a sticky stop flag when it runs out.

Top module: `cq_stall_ctrl`

## Requirements
- R1: The block address returned for an accepted request equals the request address with its low log2(BLK_BYTES) bits cleared.
- R2: Every accepted request, to either queue, receives the value of one shared tag counter, and that counter then advances by one. A rejected request does not advance it.
- R3: A queue counts as full when every slot is valid and none is in service. An accepted request that leaves the miss queue full sets mask bit 0. One that leaves the write buffer full sets mask bit 1.
- R4: Marking a slot in service clears that queue's mask bit only if the queue was full before the mark and is not full after it. It never touches the other bits.
- R5: `port_ready` is low exactly while the mask is nonzero. A request presented while `port_ready` is low is rejected (`rsp_ok` = 0).
- R6: If a request was refused while stalled, `retry_pulse` is high for exactly one cycle, and that cycle is the first one with `port_ready` high again. If no request was refused, no pulse is issued.
- R7: When the mask goes from zero to nonzero, the event counter of the lowest-numbered cause being set increments by one. Setting further causes while already stalled does not count.
- R8: When the mask returns to zero, the number of cycles it was nonzero is added to the cycle counter of the lowest-numbered cause cleared in that cycle.
- R9: The write buffer accepts only command 1 (write) and command 2 (clean evict). Commands 0 (read) and 3 (other) sent to it are rejected. The miss queue accepts all four commands.
- R10: `rsp_merge` is high for an accepted write-buffer request whose block address matches a valid write-buffer slot that is not in service.
- R11: A miss countdown loaded through `cd_load` decrements on each `miss_report` while it is nonzero. `stop_flag` sets when it steps from 1 to 0 and stays set until reset.
- R12: `tgt_set` sets mask bit 2 and `tgt_clr` clears it. When a set and a clear of the same bit fall in the same cycle, the clear wins. An allocation and an issue in the same cycle that leave a queue not full do not set its bit.
- R13: A request to a queue with no free slot is rejected. A release (`fin_valid`) frees a slot only if that slot is in service; otherwise it is ignored.
- R14: After reset, `port_ready` is 1, while the mask, `rsp_ok`, `retry_pulse`, `stop_flag` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present |
| req_to_wb | input | 1 | 1 selects the write buffer, 0 the miss queue |
| req_addr | input | ADDR_W | Request byte address |
| req_cmd | input | 2 | Command: 0 read, 1 write, 2 clean evict, 3 other |
| rsp_ok | output | 1 | Request of the previous cycle was accepted |
| rsp_tag | output | TAG_W | Order tag given to the accepted request |
| rsp_idx | output | IDX_W | Slot taken in the target queue |
| rsp_blk | output | ADDR_W | Block-aligned address |
| rsp_merge | output | 1 | Write-buffer merge candidate found |
| iss_valid | input | 1 | Mark a slot in service |
| iss_to_wb | input | 1 | Queue select for the mark |
| iss_idx | input | IDX_W | Slot to mark |
| fin_valid | input | 1 | Release a slot |
| fin_to_wb | input | 1 | Queue select for the release |
| fin_idx | input | IDX_W | Slot to release |
| tgt_set | input | 1 | Raise cause 2 (no target slots) |
| tgt_clr | input | 1 | Drop cause 2 |
| port_ready | output | 1 | Processor-side ready, low while stalled |
| retry_pulse | output | 1 | One-cycle retry after a stall with refused requests |
| blk_mask | output | 3 | Stall mask, bit n is cause n |
| blk_evt | output | 3*CNT_W | Stall episode counters, cause n at bits n*CNT_W upward |
| blk_cyc | output | 3*CYC_W | Stalled cycle counters, cause n at bits n*CYC_W upward |
| cd_load | input | 1 | Load the miss countdown |
| cd_value | input | CD_W | Countdown load value |
| miss_report | input | 1 | One miss occurred |
| stop_flag | output | 1 | Sticky countdown-expired flag |

## Verification
The bench builds the block with a four-slot miss queue, a two-slot write buffer, 2-bit slot indices and 16-byte blocks on a 16-bit address. With these sizes a handful of requests fills either queue, so the stall, the full-to-not-full release and the no-free-slot rejection all occur within a few cycles. The two-slot write buffer makes it easy to build a merge match, and to have an allocation and an issue in the same cycle. Narrow statistics counters keep the exact expected stall cycle counts small enough to compute by hand.

// File: rtl/cq_stall_pkg.sv
package cq_stall_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_CLEAN = 2'd2,
    CMD_OTHER = 2'd3
  } cq_cmd_e;

  localparam int NCAUSE    = 3;
  localparam int CAUSE_MQ  = 0;
  localparam int CAUSE_WB  = 1;
  localparam int CAUSE_TGT = 2;
endpackage

// File: rtl/cq_slot_track.sv
module cq_slot_track #(
  parameter int DEPTH    = 8,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 32,
  parameter bit MATCH_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_fire,
  input  logic [ADDR_W-1:0] alloc_blk,
  input  logic              iss_req,
  input  logic [IDX_W-1:0]  iss_idx,
  input  logic              fin_req,
  input  logic [IDX_W-1:0]  fin_idx,
  output logic              has_free,
  output logic [IDX_W-1:0]  free_idx,
  output logic              merge_hit,
  output logic              set_full,
  output logic              clr_full
);
  logic [DEPTH-1:0] vld_q, srv_q, vld_d, srv_d;
  logic [DEPTH-1:0] iss_hit, fin_hit;
  logic             full_now, full_next;

  // lowest free slot
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    srv_d = srv_q;
    for (int i = 0; i < DEPTH; i++) begin
      iss_hit[i] = iss_req && (iss_idx == IDX_W'(i)) && vld_q[i] && !srv_q[i];
      fin_hit[i] = fin_req && (fin_idx == IDX_W'(i)) && vld_q[i] && srv_q[i];
      if (fin_hit[i]) begin
        vld_d[i] = 1'b0;
        srv_d[i] = 1'b0;
      end
      if (iss_hit[i]) srv_d[i] = 1'b1;
      if (alloc_fire && (free_idx == IDX_W'(i))) begin
        vld_d[i] = 1'b1;
        srv_d[i] = 1'b0;
      end
    end
  end

  assign full_now  = &(vld_q & ~srv_q);
  assign full_next = &(vld_d & ~srv_d);
  assign set_full  = alloc_fire && full_next;
  assign clr_full  = (|iss_hit) && full_now && !full_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      srv_q <= '0;
    end else begin
      vld_q <= vld_d;
      srv_q <= srv_d;
    end
  end

  generate
    if (MATCH_EN) begin : g_match
      logic [ADDR_W-1:0] blk_mem [DEPTH];
      logic [DEPTH-1:0]  cmp;
      always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (alloc_fire && (free_idx == IDX_W'(i))) blk_mem[i] <= alloc_blk;
        end
      end
      always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
          cmp[i] = vld_q[i] && !srv_q[i] && (blk_mem[i] == alloc_blk);
        end
      end
      assign merge_hit = |cmp;
    end else begin : g_nomatch
      logic unused_blk;
      assign unused_blk = ^alloc_blk;
      assign merge_hit  = 1'b0;
    end
  endgenerate

  // R13
  no_full_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> has_free);
endmodule

// File: rtl/cq_cause_mask.sv
module cq_cause_mask #(
  parameter int NC    = 3,
  parameter int CNT_W = 16,
  parameter int CYC_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NC-1:0]       set_vec,
  input  logic [NC-1:0]       clr_vec,
  input  logic                req_seen,
  output logic [NC-1:0]       mask_q,
  output logic                port_ready,
  output logic                retry_pulse,
  output logic [NC*CNT_W-1:0] evt_flat,
  output logic [NC*CYC_W-1:0] cyc_flat
);
  logic [NC-1:0]    mask_d, on_sel, off_sel, off_src;
  logic             going_on, going_off, refused, pend_q;
  logic [CYC_W-1:0] now_q, stamp_q, elapsed;

  assign mask_d    = (mask_q | set_vec) & ~clr_vec;
  assign going_on  = (mask_q == '0) && (mask_d != '0);
  assign going_off = (mask_q != '0) && (mask_d == '0);
  assign on_sel    = mask_d & (~mask_d + 1'b1);
  assign off_src   = mask_q & clr_vec;
  assign off_sel   = off_src & (~off_src + 1'b1);
  assign refused   = req_seen && !port_ready;
  assign elapsed   = now_q - stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      port_ready  <= 1'b1;
      retry_pulse <= 1'b0;
      pend_q      <= 1'b0;
      now_q       <= '0;
      stamp_q     <= '0;
    end else begin
      mask_q      <= mask_d;
      port_ready  <= (mask_d == '0);
      retry_pulse <= going_off && (pend_q || refused);
      now_q       <= now_q + 1'b1;
      if (going_off)    pend_q <= 1'b0;
      else if (refused) pend_q <= 1'b1;
      if (going_on) stamp_q <= now_q;
    end
  end

  generate
    for (genvar c = 0; c < NC; c++) begin : g_cnt
      logic [CNT_W-1:0] evt_q;
      logic [CYC_W-1:0] cyc_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          evt_q <= '0;
          cyc_q <= '0;
        end else begin
          if (going_on && on_sel[c])   evt_q <= evt_q + 1'b1;
          if (going_off && off_sel[c]) cyc_q <= cyc_q + elapsed;
        end
      end
      assign evt_flat[c*CNT_W +: CNT_W] = evt_q;
      assign cyc_flat[c*CYC_W +: CYC_W] = cyc_q;
    end
  endgenerate

  // R5
  stall_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q != '0) |-> !port_ready);
  // R6
  retry_single_chk: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |=> !retry_pulse);
  // R6
  retry_ready_chk: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |-> port_ready);
endmodule

// File: rtl/cq_miss_count.sv
module cq_miss_count #(
  parameter int CD_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cd_load,
  input  logic [CD_W-1:0] cd_value,
  input  logic            miss_report,
  output logic            stop_flag
);
  logic [CD_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      stop_flag <= 1'b0;
    end else if (cd_load) begin
      left_q <= cd_value;
    end else if (miss_report && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
      if (left_q == CD_W'(1)) stop_flag <= 1'b1;
    end
  end

  // R11
  stop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stop_flag |=> stop_flag);
endmodule

// File: rtl/cq_stall_ctrl.sv
module cq_stall_ctrl
  import cq_stall_pkg::*;
#(
  parameter int MQ_DEPTH  = 8,
  parameter int WB_DEPTH  = 4,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int TAG_W     = 16,
  parameter int CNT_W     = 16,
  parameter int CYC_W     = 32,
  parameter int CD_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_to_wb,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_cmd,
  output logic                    rsp_ok,
  output logic [TAG_W-1:0]        rsp_tag,
  output logic [IDX_W-1:0]        rsp_idx,
  output logic [ADDR_W-1:0]       rsp_blk,
  output logic                    rsp_merge,
  input  logic                    iss_valid,
  input  logic                    iss_to_wb,
  input  logic [IDX_W-1:0]        iss_idx,
  input  logic                    fin_valid,
  input  logic                    fin_to_wb,
  input  logic [IDX_W-1:0]        fin_idx,
  input  logic                    tgt_set,
  input  logic                    tgt_clr,
  output logic                    port_ready,
  output logic                    retry_pulse,
  output logic [2:0]              blk_mask,
  output logic [3*CNT_W-1:0]      blk_evt,
  output logic [3*CYC_W-1:0]      blk_cyc,
  input  logic                    cd_load,
  input  logic [CD_W-1:0]         cd_value,
  input  logic                    miss_report,
  output logic                    stop_flag
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  logic [ADDR_W-1:0] blk_addr;
  logic              wb_cmd_ok, mq_fire, wb_fire;
  logic              mq_free, wb_free, mq_set, wb_set, mq_clr, wb_clr;
  logic              mq_merge, wb_merge;
  logic [IDX_W-1:0]  mq_idx, wb_idx;
  logic [TAG_W-1:0]  tag_q;
  logic [NCAUSE-1:0] set_vec, clr_vec;
  logic              unused_lo, unused_mq_merge;

  assign blk_addr        = {req_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
  assign unused_lo       = ^req_addr[OFS_W-1:0];
  assign unused_mq_merge = mq_merge;
  assign wb_cmd_ok       = (req_cmd == CMD_WRITE) || (req_cmd == CMD_CLEAN);
  assign mq_fire = req_valid && port_ready && !req_to_wb && mq_free;
  assign wb_fire = req_valid && port_ready && req_to_wb && wb_cmd_ok && wb_free;

  cq_slot_track #(
    .DEPTH(MQ_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MATCH_EN(1'b0)
  ) i_mq (
    .clk(clk), .rst(rst),
    .alloc_fire(mq_fire), .alloc_blk(blk_addr),
    .iss_req(iss_valid && !iss_to_wb), .iss_idx(iss_idx),
    .fin_req(fin_valid && !fin_to_wb), .fin_idx(fin_idx),
    .has_free(mq_free), .free_idx(mq_idx), .merge_hit(mq_merge),
    .set_full(mq_set), .clr_full(mq_clr)
  );

  cq_slot_track #(
    .DEPTH(WB_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MATCH_EN(1'b1)
  ) i_wb (
    .clk(clk), .rst(rst),
    .alloc_fire(wb_fire), .alloc_blk(blk_addr),
    .iss_req(iss_valid && iss_to_wb), .iss_idx(iss_idx),
    .fin_req(fin_valid && fin_to_wb), .fin_idx(fin_idx),
    .has_free(wb_free), .free_idx(wb_idx), .merge_hit(wb_merge),
    .set_full(wb_set), .clr_full(wb_clr)
  );

  assign set_vec = {tgt_set, wb_set, mq_set};
  assign clr_vec = {tgt_clr, wb_clr, mq_clr};

  cq_cause_mask #(.NC(NCAUSE), .CNT_W(CNT_W), .CYC_W(CYC_W)) i_mask (
    .clk(clk), .rst(rst),
    .set_vec(set_vec), .clr_vec(clr_vec), .req_seen(req_valid),
    .mask_q(blk_mask), .port_ready(port_ready), .retry_pulse(retry_pulse),
    .evt_flat(blk_evt), .cyc_flat(blk_cyc)
  );

  cq_miss_count #(.CD_W(CD_W)) i_cd (
    .clk(clk), .rst(rst),
    .cd_load(cd_load), .cd_value(cd_value), .miss_report(miss_report),
    .stop_flag(stop_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q     <= '0;
      rsp_ok    <= 1'b0;
      rsp_tag   <= '0;
      rsp_idx   <= '0;
      rsp_blk   <= '0;
      rsp_merge <= 1'b0;
    end else begin
      rsp_ok    <= mq_fire || wb_fire;
      rsp_merge <= wb_fire && wb_merge;
      if (mq_fire || wb_fire) begin
        tag_q   <= tag_q + 1'b1;
        rsp_tag <= tag_q;
        rsp_idx <= wb_fire ? wb_idx : mq_idx;
        rsp_blk <= blk_addr;
      end
    end
  end

  // R5
  stall_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !port_ready) |=> !rsp_ok);
  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok && $past(rsp_ok)) |-> (rsp_tag == TAG_W'($past(rsp_tag) + 1'b1)));
  // R10
  merge_wb_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_merge |-> rsp_ok);
endmodule

// File: tb/test_cq_stall_ctrl.sv
module test_cq_stall_ctrl;
  localparam int AW = 16, IW = 2, TW = 8, CW = 8, YW = 16, DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_to_wb = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_cmd = '0;
  logic          iss_valid = 0, iss_to_wb = 0, fin_valid = 0, fin_to_wb = 0;
  logic [IW-1:0] iss_idx = '0, fin_idx = '0;
  logic          tgt_set = 0, tgt_clr = 0, cd_load = 0, miss_report = 0;
  logic [DW-1:0] cd_value = '0;
  logic          rsp_ok, rsp_merge, port_ready, retry_pulse, stop_flag;
  logic [TW-1:0] rsp_tag;
  logic [IW-1:0] rsp_idx;
  logic [AW-1:0] rsp_blk;
  logic [2:0]    blk_mask;
  logic [3*CW-1:0] blk_evt;
  logic [3*YW-1:0] blk_cyc;

  cq_stall_ctrl #(
    .MQ_DEPTH(4), .WB_DEPTH(2), .IDX_W(IW), .ADDR_W(AW), .BLK_BYTES(16),
    .TAG_W(TW), .CNT_W(CW), .CYC_W(YW), .CD_W(DW)
  ) i_cq_stall_ctrl (.*);

  int checks = 0, fails = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; iss_valid = 0; fin_valid = 0;
    tgt_set = 0; tgt_clr = 0; cd_load = 0; miss_report = 0;
  endtask

  task automatic req(input logic wb, input logic [AW-1:0] a, input logic [1:0] c);
    req_valid = 1; req_to_wb = wb; req_addr = a; req_cmd = c;
  endtask

  function automatic logic [31:0] evt(input int c);
    return 32'(blk_evt[c*CW +: CW]);
  endfunction
  function automatic logic [31:0] cyc(input int c);
    return 32'(blk_cyc[c*YW +: YW]);
  endfunction

  typedef struct packed {
    logic          wb;
    logic [AW-1:0] addr;
    logic [1:0]    cmd;
    logic          ok;
    logic [TW-1:0] tag;
    logic [AW-1:0] blk;
    logic [IW-1:0] idx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h1234, 2'd0, 1'b1, 8'd0, 16'h1230, 2'd0},
    '{1'b1, 16'h0A05, 2'd0, 1'b0, 8'd0, 16'h0000, 2'd0},
    '{1'b1, 16'h0A05, 2'd3, 1'b0, 8'd0, 16'h0000, 2'd0},
    '{1'b1, 16'h0A05, 2'd1, 1'b1, 8'd1, 16'h0A00, 2'd0},
    '{1'b0, 16'hFFFF, 2'd3, 1'b1, 8'd2, 16'hFFF0, 2'd1},
    '{1'b0, 16'h0010, 2'd1, 1'b1, 8'd3, 16'h0010, 2'd2}
  };

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R14 reset state
    chk("R14 port_ready", 32'(port_ready), 1);
    chk("R14 mask", 32'(blk_mask), 0);
    chk("R14 rsp_ok", 32'(rsp_ok), 0);
    chk("R14 stop", 32'(stop_flag), 0);
    chk("R14 evt0", evt(0), 0);

    // R1 R2 R9 table walk
    foreach (VECS[i]) begin
      req(VECS[i].wb, VECS[i].addr, VECS[i].cmd);
      tick();
      chk($sformatf("R9 ok v%0d", i), 32'(rsp_ok), 32'(VECS[i].ok));
      if (VECS[i].ok) begin
        chk($sformatf("R2 tag v%0d", i), 32'(rsp_tag), 32'(VECS[i].tag));
        chk($sformatf("R1 blk v%0d", i), 32'(rsp_blk), 32'(VECS[i].blk));
        chk($sformatf("R13 idx v%0d", i), 32'(rsp_idx), 32'(VECS[i].idx));
        chk($sformatf("R10 nomerge v%0d", i), 32'(rsp_merge), 0);
      end
    end

    // R3 fill miss queue
    req(0, 16'h0020, 2'd0); tick();
    chk("R3 tag", 32'(rsp_tag), 4);
    chk("R3 mask", 32'(blk_mask), 1);
    chk("R5 stalled", 32'(port_ready), 0);
    chk("R7 evt0", evt(0), 1);
    // R5 refused while stalled
    req(1, 16'h0A0C, 2'd1); tick();
    chk("R5 reject", 32'(rsp_ok), 0);
    tick(); tick();
    chk("R6 no early retry", 32'(retry_pulse), 0);
    // R4 full to not full releases
    iss_valid = 1; iss_to_wb = 0; iss_idx = 2'd1; tick();
    chk("R4 mask", 32'(blk_mask), 0);
    chk("R5 ready", 32'(port_ready), 1);
    chk("R6 retry", 32'(retry_pulse), 1);
    chk("R8 cyc0", cyc(0), 4);
    tick();
    chk("R6 retry one cycle", 32'(retry_pulse), 0);

    // R10 merge and R3 write buffer full
    req(1, 16'h0A0C, 2'd2); tick();
    chk("R10 merge", 32'(rsp_merge), 1);
    chk("R2 tag after reject", 32'(rsp_tag), 5);
    chk("R3 wb mask", 32'(blk_mask), 2);
    chk("R7 evt1", evt(1), 1);
    // R4 issue in other queue leaves bit 1
    iss_valid = 1; iss_to_wb = 0; iss_idx = 2'd3; tick();
    chk("R4 other queue", 32'(blk_mask), 2);
    // R12 cause 2
    tgt_set = 1; tick();
    chk("R12 set", 32'(blk_mask), 6);
    chk("R7 no evt while stalled", evt(2), 0);
    iss_valid = 1; iss_to_wb = 1; iss_idx = 2'd0; tick();
    chk("R4 wb clear", 32'(blk_mask), 4);
    chk("R5 still stalled", 32'(port_ready), 0);
    tgt_clr = 1; tick();
    chk("R12 clr", 32'(blk_mask), 0);
    chk("R8 cyc2", cyc(2), 4);
    chk("R8 cyc1", cyc(1), 0);
    chk("R6 no retry", 32'(retry_pulse), 0);
    tgt_set = 1; tgt_clr = 1; tick();
    chk("R12 clear wins", 32'(blk_mask), 0);
    chk("R12 no evt", evt(2), 0);

    // R13 ignored release and no free slot
    fin_valid = 1; fin_to_wb = 0; fin_idx = 2'd0; tick();
    req(0, 16'h0040, 2'd0); tick();
    chk("R13 no free", 32'(rsp_ok), 0);
    fin_valid = 1; fin_to_wb = 0; fin_idx = 2'd1; tick();
    req(0, 16'h0040, 2'd0); tick();
    chk("R13 ok", 32'(rsp_ok), 1);
    chk("R13 idx", 32'(rsp_idx), 1);
    chk("R2 tag6", 32'(rsp_tag), 6);
    // R12 alloc and issue same cycle
    fin_valid = 1; fin_to_wb = 1; fin_idx = 2'd0; tick();
    req(1, 16'h0B00, 2'd1); iss_valid = 1; iss_to_wb = 1; iss_idx = 2'd1; tick();
    chk("R12 same cycle ok", 32'(rsp_ok), 1);
    chk("R12 same cycle mask", 32'(blk_mask), 0);
    chk("R10 no merge", 32'(rsp_merge), 0);
    chk("R2 tag7", 32'(rsp_tag), 7);

    // R11 countdown
    cd_load = 1; cd_value = 8'd2; tick();
    miss_report = 1; tick();
    chk("R11 not yet", 32'(stop_flag), 0);
    miss_report = 1; tick();
    chk("R11 stop", 32'(stop_flag), 1);
    cd_load = 1; cd_value = 8'd3; tick();
    miss_report = 1; tick();
    chk("R11 sticky", 32'(stop_flag), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule